// File: doc/BRIEF.md
# Frame-Synchronous Tile Map Updater

This block queues screen edit commands and applies them to a tile map only during the vertical blanking window. Each 24-bit command either places a symbol on a tile of a 20-column by 15-row grid or clears that tile. For a placement, the command carries the 14-bit address of the symbol's image in external memory. Commands can be pushed at any time, and up to 300 of them wait in a queue. While the drain enable is high, which the system drives during vertical sync, the block applies one queued command per clock. It turns the tile's row and column into a linear map index and writes either the symbol address or zero.

A separate read port lets the rendering side fetch the stored symbol address for any tile, with a one-cycle latency. The block reports how many commands are queued, raises full and empty flags, and gives a one-cycle pulse when a drain empties the queue. That pulse tells the frame logic that the map is up to date.

Top module: `tile_map_updater`

## Requirements
- R1: After reset the queue is empty: `cmdEmpty`=1, `cmdFull`=0, `cmdUsed`=0, and `mapUpdated` and `mapRdValid` are 0.
- R2: Each accepted push raises `cmdUsed` by one. At 300 queued commands `cmdFull`=1, and a push while full is ignored: the count stays 300 and the command never reaches the map.
- R3: While `drainEn`=0 no command is taken from the queue: `cmdUsed` holds and the map is unchanged.
- R4: While `drainEn`=1 and the queue is not empty, exactly one command is applied per clock, in push order, so that a later command to the same tile wins.
- R5: The command fields are: bit 23 = type, bits [22:9] = symbol address, bits [8:5] = row, bits [4:0] = column. The map index written is 20*row + column.
- R6: A command of type 1 (add) writes its symbol address field into the addressed map entry.
- R7: A command of type 0 (remove) writes 0 into the addressed map entry.
- R8: A command with row above 14 or column above 19 is consumed but writes no map entry.
- R9: `mapUpdated` is high for exactly one cycle after the clock edge at which a drain removes the last queued command. Draining an already empty queue gives no pulse.
- R10: A read with `mapRdEn`=1 at a clock edge gives `mapRdValid`=1 and the entry at `mapRdAddr` in the following cycle. `mapRdValid` is 0 otherwise.
- R11: Dropping `drainEn` in the middle of a queue stops application at once. Raising it again resumes with the next queued command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Push a command into the queue |
| cmdData | input | 24 | Command word |
| drainEn | input | 1 | Vertical-sync window: apply queued commands |
| cmdFull | output | 1 | Queue holds 300 commands |
| cmdEmpty | output | 1 | Queue holds no command |
| cmdUsed | output | 9 | Number of queued commands |
| mapUpdated | output | 1 | One-cycle pulse: drain emptied the queue |
| mapRdEn | input | 1 | Map read request |
| mapRdAddr | input | 9 | Map index to read (0 to 299) |
| mapRdData | output | 14 | Symbol address read from the map |
| mapRdValid | output | 1 | `mapRdData` is valid this cycle |

## Verification
A push or a drain step changes `cmdUsed` and the flags at the very next clock edge. A command applied at an edge is visible to a read issued at a later edge. Read data and `mapRdValid` appear one edge after the read request. `mapUpdated` rises at the edge that removes the last command and falls at the edge after that. The bench drives every input on the falling edge and samples on the falling edge that follows the counted number of rising edges. It therefore checks each result in exactly the cycle it is due, and checks it again one cycle later for the pulse and the valid flag.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  localparam int SYM_W = 14;
  localparam int ROW_W = 4;
  localparam int COL_W = 5;
  localparam int CMD_W = 1 + SYM_W + ROW_W + COL_W;

  typedef struct packed {
    logic             isAdd;
    logic [SYM_W-1:0] symAddr;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } tmu_cmd_t;

  typedef struct packed {
    logic push;
    logic pop;
  } tmu_strobe_t;
endpackage

// File: rtl/tmu_control.sv
module tmu_control #(
  parameter int DEPTH = 300,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdWrEn,
  input  logic                 drainEn,
  output tmu_pkg::tmu_strobe_t strb,
  output logic                 cmdFull,
  output logic                 cmdEmpty,
  output logic [CNT_W-1:0]     cmdUsed,
  output logic                 mapUpdated
);
  logic [CNT_W-1:0] usedQ;

  assign cmdFull  = (usedQ == CNT_W'(DEPTH));
  assign cmdEmpty = (usedQ == '0);
  assign cmdUsed  = usedQ;

  always_comb begin
    strb.push = cmdWrEn && !cmdFull;
    strb.pop  = drainEn && !cmdEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usedQ      <= '0;
      mapUpdated <= 1'b0;
    end else begin
      if (strb.push && !strb.pop)      usedQ <= usedQ + 1'b1;
      else if (strb.pop && !strb.push) usedQ <= usedQ - 1'b1;
      mapUpdated <= strb.pop && !strb.push && (usedQ == CNT_W'(1));
    end
  end

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdFull && cmdEmpty));
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    usedQ <= CNT_W'(DEPTH));
  a_r2_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdFull && !drainEn) |=> (usedQ == CNT_W'(DEPTH)));
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!drainEn && !cmdWrEn) |=> $stable(usedQ));
  a_r9_pulse_empty: assert property (@(posedge clk) disable iff (!rst_n)
    mapUpdated |-> cmdEmpty);
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    mapUpdated |=> !mapUpdated);
endmodule

// File: rtl/tmu_datapath.sv
module tmu_datapath #(
  parameter int DEPTH = 300,
  parameter int COLS  = 20,
  parameter int ROWS  = 15,
  localparam int CELLS  = COLS * ROWS,
  localparam int ADDR_W = $clog2(CELLS),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  tmu_pkg::tmu_strobe_t        strb,
  input  logic [tmu_pkg::CMD_W-1:0]   cmdData,
  input  logic                        mapRdEn,
  input  logic [ADDR_W-1:0]           mapRdAddr,
  output logic [tmu_pkg::SYM_W-1:0]   mapRdData,
  output logic                        mapRdValid
);
  import tmu_pkg::*;

  logic [CMD_W-1:0] queueMem [DEPTH];
  logic [SYM_W-1:0] mapMem   [CELLS];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  tmu_cmd_t         headCmd;
  logic             inRange;
  logic [ADDR_W-1:0] cellIdx;
  logic             mapWe;
  logic [SYM_W-1:0] mapWd;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) queueMem[wrPtr] <= cmdData;
  end

  always_comb begin
    headCmd = tmu_cmd_t'(queueMem[rdPtr]);
    inRange = (int'(headCmd.row) < ROWS) && (int'(headCmd.col) < COLS);
    cellIdx = ADDR_W'(headCmd.row) * ADDR_W'(COLS) + ADDR_W'(headCmd.col);
    mapWe   = strb.pop && inRange;
    mapWd   = headCmd.isAdd ? headCmd.symAddr : '0;
  end

  always_ff @(posedge clk) begin
    if (mapWe) mapMem[cellIdx] <= mapWd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mapRdValid <= 1'b0;
      mapRdData  <= '0;
    end else begin
      mapRdValid <= mapRdEn;
      if (mapRdEn) mapRdData <= mapMem[mapRdAddr];
    end
  end

  a_r8_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mapWe |-> (int'(cellIdx) < CELLS));
  a_r10_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    mapRdEn |=> mapRdValid);
  a_r10_valid_only_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    !mapRdEn |=> !mapRdValid);
  a_r4_pointers_advance: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |=> (rdPtr != $past(rdPtr)));
endmodule

// File: rtl/tile_map_updater.sv
module tile_map_updater #(
  parameter int DEPTH = 300,
  parameter int COLS  = 20,
  parameter int ROWS  = 15,
  localparam int CELLS  = COLS * ROWS,
  localparam int ADDR_W = $clog2(CELLS),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmdWrEn,
  input  logic [tmu_pkg::CMD_W-1:0]   cmdData,
  input  logic                        drainEn,
  output logic                        cmdFull,
  output logic                        cmdEmpty,
  output logic [CNT_W-1:0]            cmdUsed,
  output logic                        mapUpdated,
  input  logic                        mapRdEn,
  input  logic [ADDR_W-1:0]           mapRdAddr,
  output logic [tmu_pkg::SYM_W-1:0]   mapRdData,
  output logic                        mapRdValid
);
  tmu_pkg::tmu_strobe_t strb;

  tmu_control #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .drainEn(drainEn),
    .strb(strb), .cmdFull(cmdFull), .cmdEmpty(cmdEmpty),
    .cmdUsed(cmdUsed), .mapUpdated(mapUpdated)
  );

  tmu_datapath #(.DEPTH(DEPTH), .COLS(COLS), .ROWS(ROWS)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cmdData(cmdData),
    .mapRdEn(mapRdEn), .mapRdAddr(mapRdAddr),
    .mapRdData(mapRdData), .mapRdValid(mapRdValid)
  );
endmodule

// File: tb/tile_map_updater_tb.sv
module tile_map_updater_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [23:0] cmdData = '0;
  logic        drainEn = 1'b0;
  logic        cmdFull, cmdEmpty, mapUpdated, mapRdValid;
  logic [8:0]  cmdUsed;
  logic        mapRdEn = 1'b0;
  logic [8:0]  mapRdAddr = '0;
  logic [13:0] mapRdData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tile_map_updater dut_i (.*);

  function automatic logic [23:0] mk(input bit add, input int sym, input int row, input int col);
    return {add, 14'(sym), 4'(row), 5'(col)};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] c);
    @(negedge clk); cmdWrEn = 1'b1; cmdData = c;
    @(negedge clk); cmdWrEn = 1'b0;
  endtask

  task automatic readMap(input int idx, input string req, input int exp);
    @(negedge clk); mapRdEn = 1'b1; mapRdAddr = 9'(idx);
    @(negedge clk); mapRdEn = 1'b0;
    chk(req, "read valid", mapRdValid, 1);
    chk(req, $sformatf("map[%0d]", idx), mapRdData, exp);
    @(negedge clk);
    chk("R10", "valid drops", mapRdValid, 0);
  endtask

  // Drain n queued commands and check the completion pulse
  task automatic drainAll(input int n);
    @(negedge clk); drainEn = 1'b1;
    repeat (n) @(negedge clk);
    chk("R9", "pulse after last", mapUpdated, 1);
    chk("R4", "empty after drain", cmdEmpty, 1);
    @(negedge clk);
    chk("R9", "pulse one cycle", mapUpdated, 0);
    drainEn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "empty", cmdEmpty, 1);
    chk("R1", "full", cmdFull, 0);
    chk("R1", "used", cmdUsed, 0);
    chk("R1", "pulse", mapUpdated, 0);
    chk("R1", "valid", mapRdValid, 0);
  endtask

  task automatic t_fill_full();
    for (int i = 0; i < 300; i++) push(mk(1, i + 1, i / 20, i % 20));
    chk("R2", "used at full", cmdUsed, 300);
    chk("R2", "full flag", cmdFull, 1);
    push(mk(1, 16383, 0, 0));
    chk("R2", "used after extra push", cmdUsed, 300);
    repeat (4) @(negedge clk);
    chk("R3", "no drain holds used", cmdUsed, 300);
    @(negedge clk); drainEn = 1'b1;
    repeat (10) @(negedge clk);
    chk("R4", "one per clock", cmdUsed, 290);
    drainEn = 1'b0;
    drainAll(290);
    readMap(0, "R2", 1);
    readMap(137, "R5", 138);
    readMap(299, "R6", 300);
  endtask

  task automatic t_remove_and_hold();
    push(mk(0, 0, 0, 0));
    repeat (5) @(negedge clk);
    chk("R3", "used held", cmdUsed, 1);
    readMap(0, "R3", 1);
    drainAll(1);
    readMap(0, "R7", 0);
  endtask

  task automatic t_order_and_drop();
    push(mk(1, 100, 1, 0));
    push(mk(1, 5000, 7, 13));
    push(mk(1, 6000, 7, 13));
    push(mk(1, 777, 0, 20));
    push(mk(1, 888, 15, 0));
    drainAll(5);
    readMap(7 * 20 + 13, "R4", 6000);
    readMap(20, "R8", 100);
  endtask

  task automatic t_pause();
    push(mk(1, 11, 3, 4));
    push(mk(1, 22, 3, 5));
    push(mk(1, 33, 3, 6));
    @(negedge clk); drainEn = 1'b1;
    repeat (2) @(negedge clk);
    drainEn = 1'b0;
    chk("R11", "two applied", cmdUsed, 1);
    chk("R9", "no pulse mid-queue", mapUpdated, 0);
    repeat (3) @(negedge clk);
    chk("R11", "paused", cmdUsed, 1);
    readMap(65, "R11", 22);
    drainAll(1);
    readMap(66, "R11", 33);
  endtask

  task automatic t_empty_drain();
    @(negedge clk); drainEn = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R9", "no pulse on empty", mapUpdated, 0);
    end
    drainEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_full();
    t_remove_and_hold();
    t_order_and_drop();
    t_pause();
    t_empty_drain();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule